// File: doc/BRIEF.md
# Rotate-Mask Shift and Logic Unit

This execution unit sits in the integer datapath of a packet-oriented RISC core. It receives two operands that were already read from the register file (`src_a` in the rs position and `src_b` in the rt position). It also receives a 16-bit immediate, a 5-bit shift amount, two 5-bit mask counts and an operation code. From these it computes one 32-bit result. The unit handles the usual logic, add/subtract, compare and shift operations. It also covers the operations that packet parsing needs: a rotate followed by a mask applied from both sides, shifts whose mask is set by a register, an add that keeps two 16-bit lanes independent, and an AND whose immediate keeps the upper half of the operand.

The datapath is combinational. When `OUT_REG` is 1 (the default), a register stage sits behind it, so a result appears one clock after its operands. Add and subtract wrap modulo 2^32 and never trap. A signed-overflow flag is provided for observation only. An operation code outside the defined set gives a zero result and raises `bad_op`.

Top module: `rotmask_alu`

## Requirements
- R1: Codes 0, 1, 2 and 3 compute `src_a` AND, OR, XOR and NOR `src_b`.
- R2: Code 4 (a+b), code 5 (a-b) and code 19 (a plus sign-extended immediate) wrap modulo 2^32. `ovf` is 1 exactly when one of these three overflows as a signed operation; for every other code `ovf` is 0.
- R3: Code 17 adds bits 15:0 of both operands and bits 31:16 of both operands separately. Each lane sum is truncated to 16 bits and no carry passes into the upper lane.
- R4: Code 14 rotates `src_b` right by `shamt`. It then clears the `mask_left` most significant bits and the `mask_right` least significant bits.
- R5: Code 15 gives (`src_b` << `shamt`) AND (all-ones >> `src_a`[4:0]).
- R6: Code 16 gives (`src_b` >> `shamt`, logical) AND (all-ones << `src_a`[4:0]).
- R7: A mask count of 0 (for codes 14, 15 and 16) leaves the corresponding mask all ones. `src_a` = 0x20 therefore acts as count 0 for codes 15 and 16.
- R8: Codes 8 (left) and 9 (right logical) shift `src_b` by `shamt`. Codes 11 (left) and 12 (right logical) shift `src_b` by `src_a`[4:0], and the upper bits of `src_a` have no effect.
- R9: Code 10 (by `shamt`) and code 13 (by `src_a`[4:0]) shift `src_b` right and fill with copies of its sign bit.
- R10: Codes 22, 23 and 24 AND, OR and XOR `src_a` with the zero-extended immediate. Code 19 adds the sign-extended immediate.
- R11: Code 18 ANDs `src_a` with a word whose bits 31:16 are ones and whose bits 15:0 are the immediate.
- R12: Codes 6 (signed) and 7 (unsigned) give 1 when `src_a` < `src_b` and 0 otherwise. Codes 20 (signed) and 21 (unsigned) compare against the sign-extended immediate. Code 21 compares unsigned even though the immediate was sign-extended.
- R13: Codes 25 to 31 give a zero result with `bad_op` = 1. Every defined code gives `bad_op` = 0.
- R14: `result`, `ovf` and `bad_op` take the value of the operands present at a rising clock edge and hold it until the next edge. An active-low `rst_n` clears all three to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 5 | Operation select (codes per requirements) |
| src_a | input | 32 | First register operand (rs position) |
| src_b | input | 32 | Second register operand (rt position) |
| imm | input | 16 | Instruction immediate |
| shamt | input | 5 | Fixed shift / rotate amount |
| mask_left | input | 5 | Number of high bits cleared by rotate-and-mask |
| mask_right | input | 5 | Number of low bits cleared by rotate-and-mask |
| result | output | 32 | Registered result |
| ovf | output | 1 | Signed overflow of the add/subtract codes |
| bad_op | output | 1 | Undefined operation code |

## Verification
The assertions sample the combinational datapath at the rising clock edge. They therefore take for granted that the operation code and all operands are known and stable across that edge whenever reset is released. The stimulus changes inputs only on the falling edge and never drives X or Z. It also keeps driving defined values while reset is active, so the lane-sum, popcount-after-rotation and compare-width properties always see settled operands.

// File: rtl/rotmask_alu_pkg.sv
package rotmask_alu_pkg;

   typedef enum logic [4:0] {
      OP_AND   = 5'd0,
      OP_OR    = 5'd1,
      OP_XOR   = 5'd2,
      OP_NOR   = 5'd3,
      OP_ADD   = 5'd4,
      OP_SUB   = 5'd5,
      OP_SLT   = 5'd6,
      OP_SLTU  = 5'd7,
      OP_SLL   = 5'd8,
      OP_SRL   = 5'd9,
      OP_SRA   = 5'd10,
      OP_SLLV  = 5'd11,
      OP_SRLV  = 5'd12,
      OP_SRAV  = 5'd13,
      OP_ROTM  = 5'd14,
      OP_SLMV  = 5'd15,
      OP_SRMV  = 5'd16,
      OP_LADD  = 5'd17,
      OP_ANDHI = 5'd18,
      OP_ADDI  = 5'd19,
      OP_SLTI  = 5'd20,
      OP_SLTIU = 5'd21,
      OP_ANDI  = 5'd22,
      OP_ORI   = 5'd23,
      OP_XORI  = 5'd24
   } op_e;

   localparam int OP_W    = 5;
   localparam int OP_LAST = 24;

   typedef enum logic [1:0] {
      GRP_LOGIC = 2'd0,
      GRP_ARITH = 2'd1,
      GRP_SHIFT = 2'd2,
      GRP_NONE  = 2'd3
   } grp_e;

   function automatic grp_e op_group(input op_e op);
      case (op)
         OP_AND, OP_OR, OP_XOR, OP_NOR,
         OP_ANDHI, OP_ANDI, OP_ORI, OP_XORI:           return GRP_LOGIC;
         OP_ADD, OP_SUB, OP_SLT, OP_SLTU,
         OP_LADD, OP_ADDI, OP_SLTI, OP_SLTIU:          return GRP_ARITH;
         OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV,
         OP_SRAV, OP_ROTM, OP_SLMV, OP_SRMV:           return GRP_SHIFT;
         default:                                      return GRP_NONE;
      endcase
   endfunction

endpackage

// File: rtl/rotmask_logic_unit.sv
module rotmask_logic_unit
   import rotmask_alu_pkg::*;
#(
   parameter int W     = 32,
   parameter int IMM_W = 16
) (
   input  op_e              op,
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic [IMM_W-1:0] imm,
   output logic [W-1:0]     res
);
   localparam int HI_W = W - IMM_W;

   logic [W-1:0] imm_zx;
   logic [W-1:0] imm_hi_ones;

   assign imm_zx      = {{HI_W{1'b0}}, imm};
   assign imm_hi_ones = {{HI_W{1'b1}}, imm};

   always_comb begin
      case (op)
         OP_AND:   res = a & b;
         OP_OR:    res = a | b;
         OP_XOR:   res = a ^ b;
         OP_NOR:   res = ~(a | b);
         OP_ANDHI: res = a & imm_hi_ones;
         OP_ANDI:  res = a & imm_zx;
         OP_ORI:   res = a | imm_zx;
         OP_XORI:  res = a ^ imm_zx;
         default:  res = '0;
      endcase
   end
endmodule

// File: rtl/rotmask_arith_unit.sv
module rotmask_arith_unit
   import rotmask_alu_pkg::*;
#(
   parameter int W     = 32,
   parameter int IMM_W = 16,
   parameter int LANES = 2
) (
   input  op_e              op,
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic [IMM_W-1:0] imm,
   output logic [W-1:0]     res,
   output logic             ovf,
   output logic [W-1:0]     sum_ab
);
   localparam int HI_W   = W - IMM_W;
   localparam int LANE_W = W / LANES;

   logic [W-1:0] imm_sx;
   logic [W-1:0] diff_ab;
   logic [W-1:0] sum_ai;
   logic [W-1:0] lane_sum;
   logic         ovf_add;
   logic         ovf_sub;
   logic         ovf_addi;
   logic         lt_s_reg;
   logic         lt_u_reg;
   logic         lt_s_imm;
   logic         lt_u_imm;

   assign imm_sx  = {{HI_W{imm[IMM_W-1]}}, imm};
   assign sum_ab  = a + b;
   assign diff_ab = a - b;
   assign sum_ai  = a + imm_sx;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_sum[g*LANE_W +: LANE_W] = a[g*LANE_W +: LANE_W] + b[g*LANE_W +: LANE_W];
   end

   assign ovf_add  = (a[W-1] == b[W-1])      && (sum_ab[W-1]  != a[W-1]);
   assign ovf_sub  = (a[W-1] != b[W-1])      && (diff_ab[W-1] != a[W-1]);
   assign ovf_addi = (a[W-1] == imm_sx[W-1]) && (sum_ai[W-1]  != a[W-1]);

   assign lt_s_reg = $signed(a) < $signed(b);
   assign lt_u_reg = a < b;
   assign lt_s_imm = $signed(a) < $signed(imm_sx);
   assign lt_u_imm = a < imm_sx;

   always_comb begin
      ovf = 1'b0;
      case (op)
         OP_ADD:   begin res = sum_ab;  ovf = ovf_add;  end
         OP_SUB:   begin res = diff_ab; ovf = ovf_sub;  end
         OP_ADDI:  begin res = sum_ai;  ovf = ovf_addi; end
         OP_LADD:  res = lane_sum;
         OP_SLT:   res = {{(W-1){1'b0}}, lt_s_reg};
         OP_SLTU:  res = {{(W-1){1'b0}}, lt_u_reg};
         OP_SLTI:  res = {{(W-1){1'b0}}, lt_s_imm};
         OP_SLTIU: res = {{(W-1){1'b0}}, lt_u_imm};
         default:  res = '0;
      endcase
   end
endmodule

// File: rtl/rotmask_shift_unit.sv
module rotmask_shift_unit
   import rotmask_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  op_e               op,
   input  logic [$clog2(W)-1:0] cnt_reg,
   input  logic [W-1:0]      val,
   input  logic [$clog2(W)-1:0] shamt,
   input  logic [$clog2(W)-1:0] mask_left,
   input  logic [$clog2(W)-1:0] mask_right,
   output logic [W-1:0]      res
);
   localparam logic [W-1:0] ONES = '1;

   logic [W-1:0] rot;
   logic [W-1:0] keep_hi;
   logic [W-1:0] keep_lo;
   logic [W-1:0] sra_fix;
   logic [W-1:0] sra_var;

   assign rot     = (val >> shamt) | (val << (W - int'(shamt)));
   assign keep_hi = ONES >> mask_left;
   assign keep_lo = ONES << mask_right;
   assign sra_fix = W'($signed(val) >>> shamt);
   assign sra_var = W'($signed(val) >>> cnt_reg);

   always_comb begin
      case (op)
         OP_SLL:  res = val << shamt;
         OP_SRL:  res = val >> shamt;
         OP_SRA:  res = sra_fix;
         OP_SLLV: res = val << cnt_reg;
         OP_SRLV: res = val >> cnt_reg;
         OP_SRAV: res = sra_var;
         OP_ROTM: res = rot & keep_hi & keep_lo;
         OP_SLMV: res = (val << shamt) & (ONES >> cnt_reg);
         OP_SRMV: res = (val >> shamt) & (ONES << cnt_reg);
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/rotmask_alu.sv
module rotmask_alu
   import rotmask_alu_pkg::*;
#(
   parameter int W       = 32,
   parameter int IMM_W   = 16,
   parameter int LANES   = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [4:0]           op_code,
   input  logic [W-1:0]         src_a,
   input  logic [W-1:0]         src_b,
   input  logic [IMM_W-1:0]     imm,
   input  logic [$clog2(W)-1:0] shamt,
   input  logic [$clog2(W)-1:0] mask_left,
   input  logic [$clog2(W)-1:0] mask_right,
   output logic [W-1:0]         result,
   output logic                 ovf,
   output logic                 bad_op
);
   localparam int SH_W = $clog2(W);

   if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("rotmask_alu: W must be a power of two of at least 8");
   end
   if (IMM_W < 1 || IMM_W >= W) begin : g_bad_imm
      $error("rotmask_alu: IMM_W must lie between 1 and W-1");
   end
   if (LANES < 1 || (W % LANES) != 0) begin : g_bad_lanes
      $error("rotmask_alu: LANES must divide W");
   end

   op_e          op_c;
   grp_e         grp_c;
   logic [W-1:0] logic_res;
   logic [W-1:0] arith_res;
   logic [W-1:0] shift_res;
   logic [W-1:0] sum_ab;
   logic         arith_ovf;
   logic [W-1:0] result_c;
   logic         ovf_c;
   logic         bad_c;

   assign op_c  = op_e'(op_code);
   assign grp_c = op_group(op_c);
   assign bad_c = (int'(op_code) > OP_LAST);

   rotmask_logic_unit #(.W(W), .IMM_W(IMM_W)) u_logic (
      .op  (op_c),
      .a   (src_a),
      .b   (src_b),
      .imm (imm),
      .res (logic_res)
   );

   rotmask_arith_unit #(.W(W), .IMM_W(IMM_W), .LANES(LANES)) u_arith (
      .op     (op_c),
      .a      (src_a),
      .b      (src_b),
      .imm    (imm),
      .res    (arith_res),
      .ovf    (arith_ovf),
      .sum_ab (sum_ab)
   );

   rotmask_shift_unit #(.W(W)) u_shift (
      .op         (op_c),
      .cnt_reg    (src_a[SH_W-1:0]),
      .val        (src_b),
      .shamt      (shamt),
      .mask_left  (mask_left),
      .mask_right (mask_right),
      .res        (shift_res)
   );

   always_comb begin
      ovf_c = 1'b0;
      case (grp_c)
         GRP_LOGIC: result_c = logic_res;
         GRP_ARITH: begin result_c = arith_res; ovf_c = arith_ovf; end
         GRP_SHIFT: result_c = shift_res;
         default:   result_c = '0;
      endcase
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result <= '0;
            ovf    <= 1'b0;
            bad_op <= 1'b0;
         end else begin
            result <= result_c;
            ovf    <= ovf_c;
            bad_op <= bad_c;
         end
      end
      AST_BAD_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         bad_op |-> (result == '0)); // R13
   end else begin : g_out_comb
      assign result = result_c;
      assign ovf    = ovf_c;
      assign bad_op = bad_c;
   end

   AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bad_c |-> (result_c == '0)); // R13
   AST_OVF_ONLY_ADDSUB: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_c |-> (op_c == OP_ADD || op_c == OP_SUB || op_c == OP_ADDI)); // R2
   AST_LANE_LOW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_c == OP_LADD) |-> (result_c[W/LANES-1:0] == sum_ab[W/LANES-1:0])); // R3
   AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (op_c == OP_ROTM && mask_left == '0 && mask_right == '0)
         |-> ($countones(result_c) == $countones(src_b))); // R4
   AST_SLT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_c == OP_SLT || op_c == OP_SLTU || op_c == OP_SLTI || op_c == OP_SLTIU)
         |-> (result_c[W-1:1] == '0)); // R12
   AST_SLMV_NO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (op_c == OP_SLMV || op_c == OP_SRMV)
         |-> ($countones(result_c) <= $countones(src_b))); // R5
endmodule

// File: tb/rotmask_alu_tb.sv
`timescale 1ns/1ps
module rotmask_alu_tb;

   typedef struct packed {
      logic [3:0]  req;
      logic [4:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [15:0] imm;
      logic [4:0]  sh;
      logic [4:0]  ml;
      logic [4:0]  mr;
      logic [31:0] exp;
      logic        ovf;
      logic        bad;
   } vec_t;

   localparam int NV = 34;
   localparam vec_t VECS [NV] = '{
      '{4'd1,  5'd0,  32'hF0F0_1234, 32'h0FF0_FF00, 16'h0000, 5'd0,  5'd0, 5'd0, 32'h00F0_1200, 1'b0, 1'b0}, // R1 and
      '{4'd1,  5'd1,  32'hF0F0_1234, 32'h0FF0_FF00, 16'h0000, 5'd0,  5'd0, 5'd0, 32'hFFF0_FF34, 1'b0, 1'b0}, // R1 or
      '{4'd1,  5'd2,  32'hF0F0_1234, 32'h0FF0_FF00, 16'h0000, 5'd0,  5'd0, 5'd0, 32'hFF00_ED34, 1'b0, 1'b0}, // R1 xor
      '{4'd1,  5'd3,  32'h0000_FFFF, 32'h00FF_0000, 16'h0000, 5'd0,  5'd0, 5'd0, 32'hFF00_0000, 1'b0, 1'b0}, // R1 nor
      '{4'd2,  5'd4,  32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0,  5'd0, 5'd0, 32'h8000_0000, 1'b1, 1'b0}, // R2 add ovf
      '{4'd2,  5'd4,  32'hFFFF_FFFF, 32'h0000_0002, 16'h0000, 5'd0,  5'd0, 5'd0, 32'h0000_0001, 1'b0, 1'b0}, // R2 add wrap
      '{4'd2,  5'd5,  32'h8000_0000, 32'h0000_0001, 16'h0000, 5'd0,  5'd0, 5'd0, 32'h7FFF_FFFF, 1'b1, 1'b0}, // R2 sub ovf
      '{4'd2,  5'd5,  32'h0000_0005, 32'h0000_0007, 16'h0000, 5'd0,  5'd0, 5'd0, 32'hFFFF_FFFE, 1'b0, 1'b0}, // R2 sub neg
      '{4'd3,  5'd17, 32'h0001_FFFF, 32'h0001_0001, 16'h0000, 5'd0,  5'd0, 5'd0, 32'h0002_0000, 1'b0, 1'b0}, // R3 no carry
      '{4'd3,  5'd17, 32'hFFFF_8000, 32'h0002_8001, 16'h0000, 5'd0,  5'd0, 5'd0, 32'h0001_0001, 1'b0, 1'b0}, // R3 both wrap
      '{4'd4,  5'd14, 32'h0000_0000, 32'h1234_5678, 16'h0000, 5'd8,  5'd4, 5'd8, 32'h0812_3400, 1'b0, 1'b0}, // R4
      '{4'd7,  5'd14, 32'h0000_0000, 32'h8000_000F, 16'h0000, 5'd4,  5'd0, 5'd0, 32'hF800_0000, 1'b0, 1'b0}, // R7 R4
      '{4'd5,  5'd15, 32'h0000_000C, 32'h0000_FFFF, 16'h0000, 5'd8,  5'd0, 5'd0, 32'h000F_FF00, 1'b0, 1'b0}, // R5
      '{4'd7,  5'd15, 32'h0000_0020, 32'h0000_00FF, 16'h0000, 5'd4,  5'd0, 5'd0, 32'h0000_0FF0, 1'b0, 1'b0}, // R7 R5
      '{4'd6,  5'd16, 32'h0000_0008, 32'hF000_00FF, 16'h0000, 5'd4,  5'd0, 5'd0, 32'h0F00_0000, 1'b0, 1'b0}, // R6
      '{4'd7,  5'd16, 32'h0000_0020, 32'hF000_00FF, 16'h0000, 5'd4,  5'd0, 5'd0, 32'h0F00_000F, 1'b0, 1'b0}, // R7 R6
      '{4'd8,  5'd8,  32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 5'd31, 5'd0, 5'd0, 32'h8000_0000, 1'b0, 1'b0}, // R8 sll
      '{4'd8,  5'd9,  32'h0000_0000, 32'h8000_0000, 16'h0000, 5'd31, 5'd0, 5'd0, 32'h0000_0001, 1'b0, 1'b0}, // R8 srl
      '{4'd9,  5'd10, 32'h0000_0000, 32'h8000_0000, 16'h0000, 5'd4,  5'd0, 5'd0, 32'hF800_0000, 1'b0, 1'b0}, // R9 sra
      '{4'd8,  5'd11, 32'hFFFF_FFE3, 32'h0000_0001, 16'h0000, 5'd0,  5'd0, 5'd0, 32'h0000_0008, 1'b0, 1'b0}, // R8 sllv high bits ignored
      '{4'd8,  5'd12, 32'h0000_0024, 32'hF000_0000, 16'h0000, 5'd0,  5'd0, 5'd0, 32'h0F00_0000, 1'b0, 1'b0}, // R8 srlv
      '{4'd9,  5'd13, 32'h0000_003F, 32'h8000_0000, 16'h0000, 5'd0,  5'd0, 5'd0, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R9 srav
      '{4'd11, 5'd18, 32'h1234_5678, 32'h0000_0000, 16'h00F0, 5'd0,  5'd0, 5'd0, 32'h1234_0070, 1'b0, 1'b0}, // R11
      '{4'd10, 5'd19, 32'h0000_0010, 32'h0000_0000, 16'hFFFF, 5'd0,  5'd0, 5'd0, 32'h0000_000F, 1'b0, 1'b0}, // R10 addi sext
      '{4'd2,  5'd19, 32'h7FFF_FFF0, 32'h0000_0000, 16'h0010, 5'd0,  5'd0, 5'd0, 32'h8000_0000, 1'b1, 1'b0}, // R2 addi ovf
      '{4'd10, 5'd22, 32'hFFFF_FFFF, 32'h0000_0000, 16'h8001, 5'd0,  5'd0, 5'd0, 32'h0000_8001, 1'b0, 1'b0}, // R10 andi
      '{4'd10, 5'd23, 32'h0000_0000, 32'h0000_0000, 16'h8000, 5'd0,  5'd0, 5'd0, 32'h0000_8000, 1'b0, 1'b0}, // R10 ori
      '{4'd10, 5'd24, 32'hFFFF_0000, 32'h0000_0000, 16'hFFFF, 5'd0,  5'd0, 5'd0, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R10 xori
      '{4'd12, 5'd6,  32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0,  5'd0, 5'd0, 32'h0000_0001, 1'b0, 1'b0}, // R12 slt
      '{4'd12, 5'd7,  32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 5'd0,  5'd0, 5'd0, 32'h0000_0000, 1'b0, 1'b0}, // R12 sltu
      '{4'd12, 5'd20, 32'hFFFF_FFFE, 32'h0000_0000, 16'hFFFF, 5'd0,  5'd0, 5'd0, 32'h0000_0001, 1'b0, 1'b0}, // R12 slti
      '{4'd12, 5'd21, 32'h0000_0005, 32'h0000_0000, 16'hFFFF, 5'd0,  5'd0, 5'd0, 32'h0000_0001, 1'b0, 1'b0}, // R12 sltiu
      '{4'd13, 5'd25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd3,  5'd0, 5'd0, 32'h0000_0000, 1'b0, 1'b1}, // R13
      '{4'd13, 5'd31, 32'h1234_5678, 32'h8765_4321, 16'h1111, 5'd1,  5'd1, 5'd1, 32'h0000_0000, 1'b0, 1'b1}  // R13
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op_code = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [15:0] imm = '0;
   logic [4:0]  shamt = '0;
   logic [4:0]  mask_left = '0;
   logic [4:0]  mask_right = '0;
   logic [31:0] result;
   logic        ovf;
   logic        bad_op;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   rotmask_alu u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_code    (op_code),
      .src_a      (src_a),
      .src_b      (src_b),
      .imm        (imm),
      .shamt      (shamt),
      .mask_left  (mask_left),
      .mask_right (mask_right),
      .result     (result),
      .ovf        (ovf),
      .bad_op     (bad_op)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [4:0] sh,
                        input logic [4:0] ml, input logic [4:0] mr);
      op_code = op; src_a = a; src_b = b; imm = im;
      shamt = sh; mask_left = ml; mask_right = mr;
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R14: reset state, with a legal nonzero operation driven
      drive(5'd4, 32'h1, 32'h1, 16'h0, 5'd0, 5'd0, 5'd0);
      repeat (3) @(posedge clk);
      #1;
      check("R14 reset result", result, 32'h0);
      check("R14 reset ovf", {31'b0, ovf}, 32'h0);
      check("R14 reset bad_op", {31'b0, bad_op}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm,
               VECS[i].sh, VECS[i].ml, VECS[i].mr);
         @(posedge clk);
         #1;
         check($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].exp);
         check($sformatf("R%0d vec %0d ovf", VECS[i].req, i), {31'b0, ovf}, {31'b0, VECS[i].ovf});
         check($sformatf("R%0d vec %0d bad_op", VECS[i].req, i), {31'b0, bad_op}, {31'b0, VECS[i].bad});
      end

      // R14: one-cycle latency; output holds until the next edge
      @(negedge clk);
      drive(5'd0, 32'h0, 32'h0, 16'h0, 5'd0, 5'd0, 5'd0);
      @(posedge clk);
      #1;
      check("R14 settle", result, 32'h0);
      @(negedge clk);
      drive(5'd4, 32'h0000_0003, 32'h0000_0004, 16'h0, 5'd0, 5'd0, 5'd0);
      #1;
      check("R14 holds before edge", result, 32'h0);
      @(posedge clk);
      #1;
      check("R14 after edge", result, 32'h0000_0007);

      // R14: asynchronous reset clears a nonzero output at once
      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      check("R14 async clear", result, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R13 then R1: bad_op drops as soon as a defined code follows
      @(negedge clk);
      drive(5'd26, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 5'd0, 5'd0);
      @(posedge clk);
      #1;
      check("R13 code 26 bad_op", {31'b0, bad_op}, 32'h1);
      @(negedge clk);
      drive(5'd1, 32'h0000_00A0, 32'h0000_000B, 16'h0, 5'd0, 5'd0, 5'd0);
      @(posedge clk);
      #1;
      check("R13 defined clears bad_op", {31'b0, bad_op}, 32'h0);
      check("R1 or after bad", result, 32'h0000_00AB);

      finish_run();
   end
endmodule